// File: doc/BRIEF.md
# Dual-Mode Window/Timeout Watchdog

This block supervises a host that has to prove it is alive by sending short trigger pulses. A counter advances on a prescaled tick and measures a programmable period in tick units. A mode bit selects between two checking schemes. In window mode the period is split evenly: triggers are refused during the first, closed half and accepted during the second, open half. In timeout mode the whole period is open, which suits hosts that need to trigger more often.

A refused trigger, or a period that ends without any trigger, raises a one-cycle reset-request pulse. Every accepted trigger and every reset request starts a new period from zero. Mode and period are sampled only at the start of a period, so a change made part-way through has no effect on the period already running.

Top module: `wdt_guard`

## Requirements
- R1: While `rst` is high, `rst_req` is low, the counter is zero and `mode_win`/`period` are captured; with window mode (`mode_win`=1) captured, `open_win` reads 0 during and right after reset.
- R2: The counter advances only in cycles where `tick_en` is 1. With `tick_en` at 0 the period does not run down and no reset request appears.
- R3: In window mode, with captured period P, `open_win` is 0 while the tick count since the period start is below P>>1 and 1 from then on.
- R4: A `kick` sampled while `open_win` is 0 produces `rst_req`=1 in the following cycle.
- R5: A `kick` sampled while `open_win` is 1 is accepted: no `rst_req`, and the next period starts with a count of zero.
- R6: With no `kick`, `rst_req` goes high for one cycle in the cycle after the P-th tick since the period start.
- R7: In timeout mode (`mode_win`=0 captured) `open_win` is always 1 and a `kick` at any count, including zero, is accepted.
- R8: Changes of `mode_win` or `period` take effect only at the next period start (accepted kick, reset request or `rst`).
- R9: A `kick` in the same cycle as the final tick of the period is accepted and no reset request follows.
- R10: After a reset request the next period starts from zero in the captured mode, so its expiry falls exactly P ticks later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Prescaled tick, one clock cycle wide |
| mode_win | input | 1 | 1 = window checking, 0 = timeout checking |
| kick | input | 1 | Trigger pulse from the host |
| period | input | CW | Period length in ticks (at least 2) |
| rst_req | output | 1 | One-cycle reset request |
| open_win | output | 1 | 1 while a kick would be accepted |

## Verification
A kick and the end of the period can land in the same clock cycle. In that case the kick must be accepted and no reset request may come out. The bench provokes this by placing a kick exactly on the last tick of a window-mode period. It then judges the outcome at the port: no pulse appears in the following cycle, and the next expiry falls a full period after the kick.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
   typedef enum logic {
      WD_TIMEOUT = 1'b0,
      WD_WINDOW  = 1'b1
   } wd_mode_e;

   typedef enum logic [1:0] {
      EV_NONE  = 2'd0,
      EV_GOOD  = 2'd1,
      EV_EARLY = 2'd2,
      EV_LATE  = 2'd3
   } wd_event_e;
endpackage

// File: rtl/wdt_guard_count.sv
module wdt_guard_count #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          tick,
   input  logic          clear,
   output logic [CW-1:0] cnt
);
   always_ff @(posedge clk) begin
      if (rst || clear) cnt <= '0;
      else if (tick)    cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/wdt_guard_frame.sv
module wdt_guard_frame
   import wdt_guard_pkg::*;
#(
   parameter int CW         = 16,
   parameter int HALF_SHIFT = 1,
   parameter bit END_REG    = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          restart,
   input  wd_mode_e      mode_in,
   input  logic [CW-1:0] period_in,
   output wd_mode_e      mode_q,
   output logic [CW-1:0] closed_len,
   output logic [CW-1:0] end_idx
);
   logic [CW-1:0] per_q;

   always_ff @(posedge clk) begin
      if (rst || restart) begin
         mode_q <= mode_in;
         per_q  <= period_in;
      end
   end

   assign closed_len = per_q >> HALF_SHIFT;

   generate
      if (END_REG) begin : g_end_reg
         logic [CW-1:0] end_q;
         always_ff @(posedge clk) begin
            if (rst || restart) end_q <= period_in - 1'b1;
         end
         assign end_idx = end_q;
      end else begin : g_end_comb
         assign end_idx = per_q - 1'b1;
      end
   endgenerate
endmodule

// File: rtl/wdt_guard_judge.sv
module wdt_guard_judge
   import wdt_guard_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          tick,
   input  logic          kick,
   input  logic [CW-1:0] cnt,
   input  wd_mode_e      mode_q,
   input  logic [CW-1:0] closed_len,
   input  logic [CW-1:0] end_idx,
   output logic          restart,
   output logic          rst_req,
   output logic          open_win
);
   wd_event_e ev;

   always_comb begin
      open_win = (mode_q == WD_TIMEOUT) || (cnt >= closed_len);
      if (kick)                       ev = open_win ? EV_GOOD : EV_EARLY;
      else if (tick && cnt == end_idx) ev = EV_LATE;
      else                            ev = EV_NONE;
      restart = (ev != EV_NONE);
   end

   always_ff @(posedge clk) begin
      if (rst) rst_req <= 1'b0;
      else     rst_req <= (ev == EV_EARLY) || (ev == EV_LATE);
   end

   // R4: refused kick leads to a request one cycle later
   a_r4_early_kick: assert property (@(posedge clk) disable iff (rst)
      (kick && !open_win) |=> rst_req);
   // R5: accepted kick never requests a reset
   a_r5_good_kick: assert property (@(posedge clk) disable iff (rst)
      (kick && open_win) |=> !rst_req);
   // R9: kick on the final tick wins over expiry
   a_r9_kick_beats_end: assert property (@(posedge clk) disable iff (rst)
      (kick && tick && cnt == end_idx) |=> !rst_req);
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
   import wdt_guard_pkg::*;
#(
   parameter int CW         = 16,
   parameter int HALF_SHIFT = 1,
   parameter bit END_REG    = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          tick_en,
   input  logic          mode_win,
   input  logic          kick,
   input  logic [CW-1:0] period,
   output logic          rst_req,
   output logic          open_win
);
   generate
      if (CW < 2) begin : g_bad_cw
         $error("wdt_guard: CW must be at least 2");
      end
      if (HALF_SHIFT < 1 || HALF_SHIFT >= CW) begin : g_bad_shift
         $error("wdt_guard: HALF_SHIFT must lie in 1..CW-1");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic [CW-1:0] closed_len;
   logic [CW-1:0] end_idx;
   logic          restart;
   wd_mode_e      mode_q;
   wd_mode_e      mode_sel;

   assign mode_sel = mode_win ? WD_WINDOW : WD_TIMEOUT;

   wdt_guard_count #(.CW(CW)) u_count (
      .clk   (clk),
      .rst   (rst),
      .tick  (tick_en),
      .clear (restart),
      .cnt   (cnt)
   );

   wdt_guard_frame #(.CW(CW), .HALF_SHIFT(HALF_SHIFT), .END_REG(END_REG)) u_frame (
      .clk        (clk),
      .rst        (rst),
      .restart    (restart),
      .mode_in    (mode_sel),
      .period_in  (period),
      .mode_q     (mode_q),
      .closed_len (closed_len),
      .end_idx    (end_idx)
   );

   wdt_guard_judge #(.CW(CW)) u_judge (
      .clk        (clk),
      .rst        (rst),
      .tick       (tick_en),
      .kick       (kick),
      .cnt        (cnt),
      .mode_q     (mode_q),
      .closed_len (closed_len),
      .end_idx    (end_idx),
      .restart    (restart),
      .rst_req    (rst_req),
      .open_win   (open_win)
   );

   // R2: count frozen without a tick and without a restart
   a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
      (!tick_en && !restart) |=> $stable(cnt));
   // R10: every request is seen with the new period already at zero
   a_r10_restart_zero: assert property (@(posedge clk) disable iff (rst)
      rst_req |-> (cnt == '0));
   // R7: timeout mode never shows a closed window
   a_r7_timeout_open: assert property (@(posedge clk) disable iff (rst)
      (mode_q == WD_TIMEOUT) |-> open_win);
   // R8: captured mode only moves at a period start
   a_r8_hold_mode: assert property (@(posedge clk) disable iff (rst)
      !restart |=> $stable(mode_q));
endmodule

// File: tb/wdt_guard_bench.sv
module wdt_guard_bench;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          tick_en = 1'b1;
   logic          mode_win = 1'b1;
   logic          kick = 1'b0;
   logic [CW-1:0] period = 16'd8;
   logic          rst_req;
   logic          open_win;

   int cyc = 0;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   int exp_q[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   wdt_guard #(.CW(CW)) u_wdt_guard (
      .clk      (clk),
      .rst      (rst),
      .tick_en  (tick_en),
      .mode_win (mode_win),
      .kick     (kick),
      .period   (period),
      .rst_req  (rst_req),
      .open_win (open_win)
   );

   task automatic chk(input bit got, input bit want, input string tag);
      checks++;
      if (got !== want) begin
         errors++;
         $display("FAIL %s: actual %0b expected %0b (cycle %0d)", tag, got, want, cyc);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // waits n clocks, then kicks; bad=1 means a request is expected
   task automatic kick_at(input int n, input bit bad);
      idle(n);
      if (bad) exp_q.push_back(cyc + 1);
      kick = 1'b1;
      @(negedge clk);
      kick = 1'b0;
   endtask

   // scoreboard monitor: every rst_req must match the queue head
   always @(negedge clk) begin
      if (!rst) begin
         if (exp_q.size() > 0 && exp_q[0] == cyc) begin
            checks++;
            if (rst_req !== 1'b1) begin
               errors++;
               $display("FAIL R4/R6 request missing: actual %0b expected 1 (cycle %0d)", rst_req, cyc);
            end
            void'(exp_q.pop_front());
         end else if (rst_req !== 1'b0) begin
            checks++;
            errors++;
            $display("FAIL R5/R9 unexpected request: actual %0b expected 0 (cycle %0d)", rst_req, cyc);
         end
      end
   end

   initial begin
      idle(3);
      chk(rst_req, 1'b0, "R1 request low in reset");
      chk(open_win, 1'b0, "R1 closed after reset");
      rst = 1'b0;

      // R6 expiry in window mode, R3 window edges, P=8
      exp_q.push_back(cyc + 8);
      idle(3);
      chk(open_win, 1'b0, "R3 closed at count 3");
      idle(1);
      chk(open_win, 1'b1, "R3 open at count 4");
      idle(4);

      // R4 early kick, then R10 next period expires a full period later
      kick_at(2, 1'b1);
      chk(open_win, 1'b0, "R10 restart closed");
      exp_q.push_back(cyc + 8);
      idle(8);

      // R5 accepted kicks restart the period
      kick_at(4, 1'b0);
      chk(open_win, 1'b0, "R5 restart from zero");
      kick_at(6, 1'b0);

      // R9 kick on the final tick
      kick_at(7, 1'b0);
      chk(open_win, 1'b0, "R9 new period after collision");

      // R2 tick gating
      idle(5);
      tick_en = 1'b0;
      idle(30);
      chk(open_win, 1'b1, "R2 count held");
      tick_en = 1'b1;
      exp_q.push_back(cyc + 3);
      idle(3);

      // R8 mode change mid period, R7 timeout mode
      idle(2);
      mode_win = 1'b0;
      idle(1);
      chk(open_win, 1'b0, "R8 mode change deferred");
      kick_at(0, 1'b1);
      chk(open_win, 1'b1, "R7 open at count 0");
      kick_at(1, 1'b0);
      kick_at(0, 1'b0);
      exp_q.push_back(cyc + 8);
      idle(8);

      // R8 period change deferred: P=16 from next period
      mode_win = 1'b1;
      period = 16'd16;
      kick_at(1, 1'b0);
      idle(7);
      chk(open_win, 1'b0, "R3 P16 closed at 7");
      idle(1);
      chk(open_win, 1'b1, "R3 P16 open at 8");
      kick_at(0, 1'b0);
      period = 16'd9;
      exp_q.push_back(cyc + 16);
      idle(16);

      // odd period: closed length 9>>1 = 4
      idle(3);
      chk(open_win, 1'b0, "R3 P9 closed at 3");
      idle(1);
      chk(open_win, 1'b1, "R3 P9 open at 4");
      kick_at(0, 1'b0);
      idle(2);

      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R6 pending requests: actual %0d expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule